// File: doc/BRIEF.md
# Split Read Completion Boundary Checker

This block sits on the target side of a split-transaction bridge. It decides how each incoming request is answered and, for memory reads, produces the split completion descriptors that follow. Each request arrives with a start address, an encoded byte count, a tag, a flag that says the address hit one of the bridge's windows, a retry indication, and flags that mark accesses to the control/status register space. It also arrives with the exclusive upper bound of the matching window. The data path, the bus pin protocol and the parity logic are not modelled. The block produces only the decisions and the descriptors.

A memory read that hits and is not retried always gets a split termination. One cycle later it gets one completion descriptor, or two. If the read runs past the window bound, the first descriptor is a normal completion that covers the bytes up to the bound. A second descriptor then flags the rest of the length as "byte count out of range". Register-space accesses get an immediate termination with no wait. If such an access reports a parity error, it is flagged in the same cycle.

Top module: `splitrd_responder`

## Requirements
- R1: After reset, `term_valid`, `term_perr` and `cpl_valid` are 0 and `req_ready` is 1.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. For an accepted hit, `term_valid` is 1 for exactly the next cycle, with `term_kind` as follows. 1 (retry) when `req_retry` is 1. Otherwise 2 (immediate) when `req_csr` is 1. Otherwise 0 (split) for a read (`req_wr`=0). A non-register write gets no termination and no descriptor.
- R3: A request with `req_hit`=0 produces no termination and no descriptor.
- R4: A retried or immediate request produces no completion descriptor.
- R5: `req_bcnt` encodes the length in bytes, with the value 0 meaning 4096. `cpl_bcnt` gives the true length, from 1 to 4096.
- R6: A split read where start address plus length is at most `bar_limit` yields exactly one descriptor. That descriptor has `cpl_err`=0, the full length and the start address. This holds even when the range crosses a 4 KB page boundary.
- R7: A split read where start address plus length exceeds `bar_limit` yields a normal descriptor and then an error descriptor. The normal descriptor has `cpl_err`=0, the start address and `bar_limit`−start bytes. The error descriptor has `cpl_err`=1, address `bar_limit` and the remaining bytes. If the start address is already at or above `bar_limit`, only the error descriptor, covering the full length, is produced.
- R8: Every descriptor carries the tag of its request. A descriptor becomes valid in the cycle after acceptance. It stays valid, with unchanged fields, until a rising edge with `cpl_ready`=1.
- R9: `req_ready` is 0 while any descriptor of the current request is still pending.
- R10: `term_perr` is 1 together with an immediate termination when `req_perr` was 1 on that accepted register access. It is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | AW | Start byte address |
| req_bcnt | input | 12 | Encoded byte count (0 = 4096) |
| req_tag | input | TW | Request tag |
| req_hit | input | 1 | Address decoded to this bridge |
| req_retry | input | 1 | Request is to be retried |
| req_csr | input | 1 | Access targets register space |
| req_wr | input | 1 | Access is a write |
| req_perr | input | 1 | Address/data/attribute parity error seen |
| bar_limit | input | AW | Exclusive upper bound of the hit window |
| term_valid | output | 1 | Termination decision valid |
| term_kind | output | 2 | 0 split, 1 retry, 2 immediate |
| term_perr | output | 1 | Register access with parity error |
| cpl_valid | output | 1 | Completion descriptor valid |
| cpl_ready | input | 1 | Descriptor consumer ready |
| cpl_addr | output | AW | Descriptor start address |
| cpl_bcnt | output | 13 | Descriptor byte count (1..4096) |
| cpl_tag | output | TW | Descriptor tag |
| cpl_err | output | 1 | Byte count out of range |

## Verification
The split termination pulse and the first completion descriptor appear in the same cycle. The bench checks that both are present at the one sample taken after acceptance, and that the descriptor fields match values computed from the address, length and bound. It then holds `cpl_ready` low for a variable number of cycles before each descriptor is consumed. Through these stalls the descriptor must stay unchanged and `req_ready` must stay low. The addresses are swept across the window bound and across a 4 KB page edge, with lengths from 1 to 4096.

// File: rtl/splitrd_pkg.sv
// Shared types for the split read responder.
// Assumes term kind encoding is fixed by the block's port contract.
package splitrd_pkg;
    typedef enum logic [1:0] {
        TK_SPLIT = 2'd0,
        TK_RETRY = 2'd1,
        TK_IMMED = 2'd2
    } term_kind_t;

    localparam int BCW = 12;        // encoded byte count width
    localparam int LENW = BCW + 1;  // true length width (1..4096)

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_NORM = 2'd1,
        SQ_ERR  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/splitrd_classify.sv
// Combinational request classifier.
// Decides the termination kind and splits the length at the window bound.
// Assumes bar_limit is the exclusive end of the window and lengths <= 4096.
module splitrd_classify
    import splitrd_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0]   addr,
    input  logic [BCW-1:0]  bcnt_code,
    input  logic            hit,
    input  logic            retry,
    input  logic            csr,
    input  logic            wr,
    input  logic            perr,
    input  logic [AW-1:0]   limit,
    output logic            issue,
    output term_kind_t      kind,
    output logic            perr_flag,
    output logic            do_split,
    output logic [LENW-1:0] norm_len,
    output logic [LENW-1:0] err_len,
    output logic [AW-1:0]   err_addr
);
    logic [LENW-1:0] full_len;
    logic [AW:0]     end_addr;
    logic            crosses;
    logic [AW-1:0]   room;

    // Decode termination kind with retry first, then register space, then read.
    always_comb begin
        issue = 1'b0;
        kind  = TK_SPLIT;
        if (hit) begin
            if (retry) begin
                issue = 1'b1;
                kind  = TK_RETRY;
            end else if (csr) begin
                issue = 1'b1;
                kind  = TK_IMMED;
            end else if (!wr) begin
                issue = 1'b1;
                kind  = TK_SPLIT;
            end
        end
        perr_flag = hit && !retry && csr && perr;
        do_split  = issue && (kind == TK_SPLIT);
    end

    // Length decode and split of the range at the window bound.
    always_comb begin
        full_len = (bcnt_code == '0) ? LENW'(4096) : {1'b0, bcnt_code};
        end_addr = {1'b0, addr} + (AW+1)'(full_len);
        crosses  = end_addr > {1'b0, limit};
        room     = (addr < limit) ? (limit - addr) : '0;
        norm_len = crosses ? room[LENW-1:0] : full_len;
        err_len  = full_len - norm_len;
        err_addr = (addr < limit) ? limit : addr;
    end
endmodule

// File: rtl/splitrd_cpl_seq.sv
// Completion descriptor sequencer.
// Emits the normal descriptor then the error descriptor over valid/ready.
// Assumes accept is only raised while busy is low.
module splitrd_cpl_seq
    import splitrd_pkg::*;
#(
    parameter int AW = 32,
    parameter int TW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            accept,
    input  logic            do_split,
    input  logic [AW-1:0]   addr,
    input  logic [TW-1:0]   tag,
    input  logic [LENW-1:0] norm_len,
    input  logic [LENW-1:0] err_len,
    input  logic [AW-1:0]   err_addr,
    output logic            busy,
    output logic            cpl_valid,
    input  logic            cpl_ready,
    output logic [AW-1:0]   cpl_addr,
    output logic [LENW-1:0] cpl_bcnt,
    output logic [TW-1:0]   cpl_tag,
    output logic            cpl_err
);
    seq_state_t      state_q;
    logic [LENW-1:0] pend_len_q;
    logic [AW-1:0]   pend_addr_q;

    // State and held descriptor update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= SQ_IDLE;
            cpl_addr    <= '0;
            cpl_bcnt    <= '0;
            cpl_tag     <= '0;
            cpl_err     <= 1'b0;
            pend_len_q  <= '0;
            pend_addr_q <= '0;
        end else begin
            case (state_q)
                SQ_IDLE: begin
                    if (accept && do_split) begin
                        cpl_tag     <= tag;
                        pend_len_q  <= err_len;
                        pend_addr_q <= err_addr;
                        if (norm_len != '0) begin
                            state_q  <= SQ_NORM;
                            cpl_addr <= addr;
                            cpl_bcnt <= norm_len;
                            cpl_err  <= 1'b0;
                        end else begin
                            state_q  <= SQ_ERR;
                            cpl_addr <= err_addr;
                            cpl_bcnt <= err_len;
                            cpl_err  <= 1'b1;
                        end
                    end
                end
                SQ_NORM: begin
                    if (cpl_ready) begin
                        if (pend_len_q != '0) begin
                            state_q  <= SQ_ERR;
                            cpl_addr <= pend_addr_q;
                            cpl_bcnt <= pend_len_q;
                            cpl_err  <= 1'b1;
                        end else begin
                            state_q <= SQ_IDLE;
                        end
                    end
                end
                SQ_ERR: begin
                    if (cpl_ready) state_q <= SQ_IDLE;
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    // Handshake outputs from state.
    always_comb begin
        cpl_valid = (state_q != SQ_IDLE);
        busy      = cpl_valid;
    end
endmodule

// File: rtl/splitrd_responder.sv
// Top of the split read responder.
// Registers the termination decision and drives the descriptor sequencer.
// Assumes bar_limit describes the window that req_hit refers to.
module splitrd_responder
    import splitrd_pkg::*;
#(
    parameter int AW = 32,
    parameter int TW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic [11:0]   req_bcnt,
    input  logic [TW-1:0] req_tag,
    input  logic          req_hit,
    input  logic          req_retry,
    input  logic          req_csr,
    input  logic          req_wr,
    input  logic          req_perr,
    input  logic [AW-1:0] bar_limit,
    output logic          term_valid,
    output logic [1:0]    term_kind,
    output logic          term_perr,
    output logic          cpl_valid,
    input  logic          cpl_ready,
    output logic [AW-1:0] cpl_addr,
    output logic [12:0]   cpl_bcnt,
    output logic [TW-1:0] cpl_tag,
    output logic          cpl_err
);
    logic            issue, perr_flag, do_split, busy, accept;
    term_kind_t      kind;
    logic [LENW-1:0] norm_len, err_len;
    logic [AW-1:0]   err_addr;

    // Request acceptance when no descriptor is pending.
    always_comb begin
        req_ready = !busy;
        accept    = req_valid && req_ready;
    end

    splitrd_classify #(.AW(AW)) cls_i (
        .addr      (req_addr),
        .bcnt_code (req_bcnt),
        .hit       (req_hit),
        .retry     (req_retry),
        .csr       (req_csr),
        .wr        (req_wr),
        .perr      (req_perr),
        .limit     (bar_limit),
        .issue     (issue),
        .kind      (kind),
        .perr_flag (perr_flag),
        .do_split  (do_split),
        .norm_len  (norm_len),
        .err_len   (err_len),
        .err_addr  (err_addr)
    );

    // One-cycle termination pulse after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            term_valid <= 1'b0;
            term_kind  <= 2'd0;
            term_perr  <= 1'b0;
        end else begin
            term_valid <= accept && issue;
            term_kind  <= kind;
            term_perr  <= accept && perr_flag;
        end
    end

    splitrd_cpl_seq #(.AW(AW), .TW(TW)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .do_split  (do_split),
        .addr      (req_addr),
        .tag       (req_tag),
        .norm_len  (norm_len),
        .err_len   (err_len),
        .err_addr  (err_addr),
        .busy      (busy),
        .cpl_valid (cpl_valid),
        .cpl_ready (cpl_ready),
        .cpl_addr  (cpl_addr),
        .cpl_bcnt  (cpl_bcnt),
        .cpl_tag   (cpl_tag),
        .cpl_err   (cpl_err)
    );
endmodule

// File: rtl/splitrd_responder_chk.sv
// Assertion checker for splitrd_responder, attached by bind.
// Assumes the port contract stated in the brief.
module splitrd_responder_chk #(
    parameter int AW = 32,
    parameter int TW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          req_hit,
    input logic          req_csr,
    input logic          req_retry,
    input logic          term_valid,
    input logic [1:0]    term_kind,
    input logic          term_perr,
    input logic          cpl_valid,
    input logic          cpl_ready,
    input logic [AW-1:0] cpl_addr,
    input logic [12:0]   cpl_bcnt,
    input logic [TW-1:0] cpl_tag,
    input logic          cpl_err
);
    // R8
    desc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid && !cpl_ready |=> cpl_valid && $stable(cpl_addr) && $stable(cpl_bcnt)
            && $stable(cpl_tag) && $stable(cpl_err));
    // R5
    bcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |-> (cpl_bcnt != 13'd0) && (cpl_bcnt <= 13'd4096));
    // R7
    err_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid && cpl_err && cpl_ready |=> !cpl_valid);
    // R4
    no_cpl_nonsplit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        term_valid && (term_kind != 2'd0) |-> !cpl_valid);
    // R2
    split_has_cpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        term_valid && (term_kind == 2'd0) |-> cpl_valid);
    // R10
    perr_immed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        term_perr |-> term_valid && (term_kind == 2'd2));
    // R9
    ready_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |-> !req_ready);
    // R3
    miss_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !req_hit |=> !term_valid);
    // R2
    term_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_hit && (req_retry || req_csr) |=> term_valid);
endmodule

bind splitrd_responder splitrd_responder_chk #(.AW(AW), .TW(TW)) chk_i (.*);

// File: tb/splitrd_responder_tb_top.sv
module splitrd_responder_tb_top;
    localparam int AW = 16;
    localparam int TW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [11:0]   req_bcnt = '0;
    logic [TW-1:0] req_tag = '0;
    logic          req_hit = 1'b0, req_retry = 1'b0, req_csr = 1'b0;
    logic          req_wr = 1'b0, req_perr = 1'b0;
    logic [AW-1:0] bar_limit = '0;
    logic          term_valid, term_perr, cpl_valid, cpl_err;
    logic [1:0]    term_kind;
    logic          cpl_ready = 1'b0;
    logic [AW-1:0] cpl_addr;
    logic [12:0]   cpl_bcnt;
    logic [TW-1:0] cpl_tag;

    int n_chk = 0;
    int n_bad = 0;
    int stall_seed = 0;

    always #4 clk = ~clk;

    splitrd_responder #(.AW(AW), .TW(TW)) dut_i (.*);

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Consume one descriptor after a stall, checking hold and fields.
    task automatic take_desc(input logic [AW-1:0] ea, input int el, input logic [TW-1:0] et,
                             input bit ee, input string req);
        int st;
        st = stall_seed % 3;
        stall_seed++;
        for (int i = 0; i < st; i++) begin
            chk(cpl_valid == 1'b1, "R8 hold valid", cpl_valid, 1);
            chk(req_ready == 1'b0, "R9 ready low", req_ready, 0);
            @(negedge clk);
        end
        chk(cpl_valid == 1'b1, req, cpl_valid, 1);
        chk(cpl_addr == ea, req, cpl_addr, ea);
        chk(cpl_bcnt == 13'(el), "R5 bcnt", cpl_bcnt, el);
        chk(cpl_tag == et, "R8 tag", cpl_tag, et);
        chk(cpl_err == ee, req, cpl_err, ee);
        cpl_ready = 1'b1;
        @(negedge clk);
        cpl_ready = 1'b0;
    endtask

    // Issue one request; expk = -1 means no termination expected.
    task automatic send(input logic [AW-1:0] a, input logic [11:0] bc, input logic [TW-1:0] t,
                        input bit hit, input bit rty, input bit csr, input bit wr, input bit pe,
                        input int expk, input string req);
        req_addr = a; req_bcnt = bc; req_tag = t; req_hit = hit; req_retry = rty;
        req_csr = csr; req_wr = wr; req_perr = pe; req_valid = 1'b1;
        chk(req_ready == 1'b1, "R9 ready idle", req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        if (expk < 0) begin
            chk(term_valid == 1'b0, req, term_valid, 0);
        end else begin
            chk(term_valid == 1'b1 && term_kind == 2'(expk), req, {term_valid, term_kind}, {1'b1, 2'(expk)});
        end
        chk(term_perr == (expk == 2 && pe), "R10 perr", term_perr, (expk == 2 && pe));
    endtask

    task automatic split_case(input logic [AW-1:0] a, input logic [11:0] bc, input logic [TW-1:0] t,
                              input string req);
        int len, room, nl;
        len = (bc == 0) ? 4096 : int'(bc);
        room = (a < bar_limit) ? int'(bar_limit) - int'(a) : 0;
        nl = (int'(a) + len > int'(bar_limit)) ? room : len;
        send(a, bc, t, 1, 0, 0, 0, 0, 0, "R2 split term");
        if (nl > 0) take_desc(a, nl, t, 1'b0, req);
        if (len - nl > 0) take_desc((a < bar_limit) ? bar_limit : a, len - nl, t, 1'b1, "R7 err desc");
        chk(cpl_valid == 1'b0, req, cpl_valid, 0);
        chk(term_valid == 1'b0, "R2 one pulse", term_valid, 0);
    endtask

    initial begin
        int lim;
        int dl [9] = '{4097, 4096, 4095, 2048, 100, 4, 1, 0, -8};
        int bl [6] = '{0, 1, 4, 100, 2048, 4095};
        int tg;
        repeat (3) @(negedge clk);
        chk(term_valid == 0 && term_perr == 0 && cpl_valid == 0, "R1 reset", {term_valid, term_perr, cpl_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
        tg = 0;
        bar_limit = 16'h8000;
        lim = 16'h8000;
        foreach (dl[i]) foreach (bl[j]) begin
            split_case(16'(lim - dl[i]), 12'(bl[j]), 5'(tg), "R6 R7 norm desc");
            tg++;
        end
        // Page-crossing reads well inside the window.
        split_case(16'h0FF0, 12'd64, 5'd3, "R6 page cross");
        split_case(16'h1F00, 12'd0, 5'd9, "R6 page cross 4096");
        bar_limit = 16'h2100;
        split_case(16'h1FFC, 12'd0, 5'd17, "R7 cross after page");
        // Retry, immediate, miss, ignored write.
        send(16'h1000, 12'd8, 5'd1, 1, 1, 0, 0, 0, 1, "R2 retry");
        chk(cpl_valid == 1'b0, "R4 retry no desc", cpl_valid, 0);
        send(16'h1000, 12'd4, 5'd2, 1, 1, 1, 0, 1, 1, "R2 retry beats csr");
        send(16'h0040, 12'd4, 5'd2, 1, 0, 1, 0, 0, 2, "R2 csr read immediate");
        chk(cpl_valid == 1'b0, "R4 immed no desc", cpl_valid, 0);
        send(16'h0040, 12'd4, 5'd2, 1, 0, 1, 1, 1, 2, "R10 csr write perr");
        send(16'h0044, 12'd4, 5'd4, 1, 0, 1, 0, 1, 2, "R10 csr read perr");
        send(16'h1000, 12'd8, 5'd5, 0, 0, 0, 0, 0, -1, "R3 miss");
        chk(cpl_valid == 1'b0, "R3 miss no desc", cpl_valid, 0);
        send(16'h1000, 12'd8, 5'd5, 0, 0, 1, 0, 1, -1, "R3 miss csr");
        send(16'h1000, 12'd8, 5'd6, 1, 0, 0, 1, 0, -1, "R2 mem write ignored");
        chk(cpl_valid == 1'b0, "R2 mem write no desc", cpl_valid, 0);
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule